// File: doc/BRIEF.md
# External Interrupt Sense Controller

This block watches eight external interrupt pins and one non-maskable interrupt pin. It turns activity on them into latched request flags, which it forwards to a parent interrupt controller. Each pin is first brought into the clock domain by a two-flop synchroniser. The block then compares the synchronised value with its value one clock earlier to find edges.

Software picks one of four sense modes for each general line: active-low level, falling edge, rising edge or both edges. For the NMI pin it picks a single edge direction. Pending flags are cleared by writing 0 to them, and bits written as 1 leave their flags untouched. A small 16-bit register port with a valid/write/address/data handshake exposes three registers: a control register at byte offset 0, a sense-select register at offset 2 and a request-status register at offset 4.

Priority, vectoring and masking belong to the parent controller. Each request output simply follows its flag.

Each general line holds its flag in a two-state machine. The states are `FLAG_IDLE` and `FLAG_PEND`, and there are three transitions:
- *raise*: `FLAG_IDLE` to `FLAG_PEND` on a sense event.
- *clear*: `FLAG_PEND` to `FLAG_IDLE` on a zero write with no event in the same cycle.
- *hold*: the state stays as it is in every other case.

In level-low mode the state is forced each cycle from the inverted synchronised pin. The NMI flag uses the same two states and the same three transitions.

Top module: `extirq_sense_ctrl`

## Requirements
- R1: After reset, the sense-select and request-status registers read 0, the control register reads 0x8000 while the NMI pin is high, and `irq_req` and `nmi_req` are low.
- R2: Only byte offsets 0, 2 and 4 are decoded. Reads of any other offset return 0, and writes to any other offset change no register.
- R3: Line n takes its sense mode from bits [2n+1:2n] of the sense-select register (offset 2), and all 16 bits read back as written.
- R4: With sense code 0 (level-low), the flag of a line equals the inverted synchronised pin. A zero write to clear it has no lasting effect while the pin stays low.
- R5: Sense code 1 raises the flag on a falling edge, code 2 on a rising edge and code 3 on either edge. A code-1 or code-2 line ignores the opposite edge.
- R6: A pin change shows on the flag after the third rising clock edge that follows it, and not after the second.
- R7: The request-status register (offset 4) holds the flag of line n in bit n, with bits [15:8] reading 0. Writing 0 to bit n clears an edge-mode flag, and writing 1 leaves it unchanged.
- R8: If a sense event and a clearing write hit the same flag in the same cycle, the flag stays set.
- R9: Bit 15 of the control register reads the synchronised NMI pin level, two clocks behind the pin. Writes to this bit have no effect.
- R10: Bit 8 of the control register selects the NMI edge: 0 for falling and 1 for rising. It reads back as written.
- R11: Bit 1 of the control register is set by the selected NMI edge and not by the other edge. Writing 0 to it clears it, and writing 1 leaves it unchanged.
- R12: `irq_req[n]` always equals the flag of line n, and `nmi_req` always equals the NMI flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | NUM_LINES | Asynchronous external interrupt pins |
| nmi_pin | input | 1 | Asynchronous NMI pin |
| bus_valid | input | 1 | Register access strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, combinational, 0 when no read is active |
| irq_req | output | NUM_LINES | Per-line request to the parent controller |
| nmi_req | output | 1 | NMI request to the parent controller |

## Verification
The bench builds the block with its default parameters: eight lines, 16-bit data and a 3-bit address. This small configuration lets a full sweep cover every line in every one of the four sense codes, with both pin directions and a clearing write for each. Expected flag patterns are computed arithmetically from the line index and the sense code. The same configuration brings within reach the cycle-exact latency boundary, the event-versus-clear collision and both NMI edge selections in each direction.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    typedef enum logic [1:0] {
        SENSE_LEVEL_LOW = 2'd0,
        SENSE_FALL      = 2'd1,
        SENSE_RISE      = 2'd2,
        SENSE_BOTH      = 2'd3
    } sense_mode_e;

    typedef enum logic {
        FLAG_IDLE = 1'b0,
        FLAG_PEND = 1'b1
    } flag_state_e;

    localparam int REG_CTRL_OFS  = 0;
    localparam int REG_SENSE_OFS = 2;
    localparam int REG_STAT_OFS  = 4;

    localparam int CTRL_LEVEL_BIT = 15;
    localparam int CTRL_EDGE_BIT  = 8;
    localparam int CTRL_FLAG_BIT  = 1;

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int   WIDTH      = 1,
    parameter logic IDLE_LEVEL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_async,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] level_prev
);

    logic [WIDTH-1:0] meta_q;

    // two synchroniser stages plus one history stage for edge compare
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q     <= {WIDTH{IDLE_LEVEL}};
            level      <= {WIDTH{IDLE_LEVEL}};
            level_prev <= {WIDTH{IDLE_LEVEL}};
        end else begin
            meta_q     <= pin_async;
            level      <= meta_q;
            level_prev <= level;
        end
    end

endmodule

// File: rtl/extirq_line.sv
module extirq_line
    import extirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        level,
    input  logic        level_prev,
    input  sense_mode_e mode,
    input  logic        clr_req,
    output logic        pending
);

    flag_state_e state_q;
    flag_state_e state_d;
    logic        event_hit;

    always_comb begin
        unique case (mode)
            SENSE_LEVEL_LOW: event_hit = !level;
            SENSE_FALL:      event_hit = level_prev && !level;
            SENSE_RISE:      event_hit = !level_prev && level;
            SENSE_BOTH:      event_hit = level ^ level_prev;
            default:         event_hit = 1'b0;
        endcase
    end

    // raise / clear / hold; level mode is forced from the pin every cycle
    always_comb begin
        if (mode == SENSE_LEVEL_LOW) begin
            state_d = event_hit ? FLAG_PEND : FLAG_IDLE;
        end else begin
            unique case (state_q)
                FLAG_IDLE: state_d = event_hit ? FLAG_PEND : FLAG_IDLE;
                FLAG_PEND: state_d = (event_hit || !clr_req) ? FLAG_PEND : FLAG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb pending = (state_q == FLAG_PEND);

endmodule

// File: rtl/extirq_nmi.sv
module extirq_nmi
    import extirq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    input  logic level_prev,
    input  logic edge_rise,
    input  logic clr_req,
    output logic pending
);

    flag_state_e state_q;
    flag_state_e state_d;
    logic        event_hit;

    always_comb begin
        event_hit = edge_rise ? (!level_prev && level) : (level_prev && !level);
    end

    always_comb begin
        unique case (state_q)
            FLAG_IDLE: state_d = event_hit ? FLAG_PEND : FLAG_IDLE;
            FLAG_PEND: state_d = (event_hit || !clr_req) ? FLAG_PEND : FLAG_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FLAG_IDLE;
        else        state_q <= state_d;
    end

    always_comb pending = (state_q == FLAG_PEND);

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_valid,
    input  logic                   bus_write,
    input  logic [ADDR_W-1:0]      bus_addr,
    input  logic [DATA_W-1:0]      bus_wdata,
    output logic [DATA_W-1:0]      bus_rdata,
    input  logic [NUM_LINES-1:0]   line_pending,
    input  logic                   nmi_pending,
    input  logic                   nmi_level,
    output logic [2*NUM_LINES-1:0] sense_q,
    output logic                   nmi_rise_q,
    output logic [NUM_LINES-1:0]   line_clr,
    output logic                   nmi_clr
);

    localparam int SENSE_W = 2 * NUM_LINES;

    logic sel_ctrl, sel_sense, sel_stat;
    logic wr_en, rd_en;

    always_comb begin
        sel_ctrl  = (bus_addr == ADDR_W'(REG_CTRL_OFS));
        sel_sense = (bus_addr == ADDR_W'(REG_SENSE_OFS));
        sel_stat  = (bus_addr == ADDR_W'(REG_STAT_OFS));
        wr_en     = bus_valid && bus_write;
        rd_en     = bus_valid && !bus_write;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sense_q    <= '0;
            nmi_rise_q <= 1'b0;
        end else begin
            if (wr_en && sel_sense) sense_q    <= bus_wdata[SENSE_W-1:0];
            if (wr_en && sel_ctrl)  nmi_rise_q <= bus_wdata[CTRL_EDGE_BIT];
        end
    end

    always_comb begin
        line_clr = (wr_en && sel_stat) ? ~bus_wdata[NUM_LINES-1:0] : '0;
        nmi_clr  = wr_en && sel_ctrl && !bus_wdata[CTRL_FLAG_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        if (rd_en) begin
            if (sel_ctrl) begin
                bus_rdata[CTRL_LEVEL_BIT] = nmi_level;
                bus_rdata[CTRL_EDGE_BIT]  = nmi_rise_q;
                bus_rdata[CTRL_FLAG_BIT]  = nmi_pending;
            end else if (sel_sense) begin
                bus_rdata[SENSE_W-1:0] = sense_q;
            end else if (sel_stat) begin
                bus_rdata[NUM_LINES-1:0] = line_pending;
            end
        end
    end

endmodule

// File: rtl/extirq_sense_ctrl.sv
module extirq_sense_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_pin,
    input  logic                 nmi_pin,
    input  logic                 bus_valid,
    input  logic                 bus_write,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic [NUM_LINES-1:0] irq_req,
    output logic                 nmi_req
);

    logic [NUM_LINES-1:0]   irq_level, irq_prev, line_pending, line_clr;
    logic [2*NUM_LINES-1:0] sense_q;
    logic nmi_level, nmi_prev, nmi_pending, nmi_clr, nmi_rise_q;

    extirq_sync #(.WIDTH(NUM_LINES), .IDLE_LEVEL(1'b1)) u_irq_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(irq_pin),
        .level(irq_level), .level_prev(irq_prev)
    );

    extirq_sync #(.WIDTH(1), .IDLE_LEVEL(1'b1)) u_nmi_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(nmi_pin),
        .level(nmi_level), .level_prev(nmi_prev)
    );

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
        extirq_line u_line (
            .clk        (clk),
            .rst_n      (rst_n),
            .level      (irq_level[i]),
            .level_prev (irq_prev[i]),
            .mode       (sense_mode_e'(sense_q[2*i +: 2])),
            .clr_req    (line_clr[i]),
            .pending    (line_pending[i])
        );
    end

    extirq_nmi u_nmi (
        .clk(clk), .rst_n(rst_n), .level(nmi_level), .level_prev(nmi_prev),
        .edge_rise(nmi_rise_q), .clr_req(nmi_clr), .pending(nmi_pending)
    );

    extirq_regs #(.NUM_LINES(NUM_LINES), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .line_pending(line_pending), .nmi_pending(nmi_pending), .nmi_level(nmi_level),
        .sense_q(sense_q), .nmi_rise_q(nmi_rise_q),
        .line_clr(line_clr), .nmi_clr(nmi_clr)
    );

    assign irq_req = line_pending;
    assign nmi_req = nmi_pending;

endmodule

// File: rtl/extirq_sense_ctrl_chk.sv
module extirq_sense_ctrl_chk
    import extirq_pkg::*;
#(
    parameter int NUM_LINES = 8,
    parameter int ADDR_W    = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_valid,
    input logic                   bus_write,
    input logic [ADDR_W-1:0]      bus_addr,
    input logic [NUM_LINES-1:0]   wdata_lo,
    input logic [NUM_LINES-1:0]   rdata_lo,
    input logic [NUM_LINES-1:0]   irq_req,
    input logic                   nmi_req,
    input logic [2*NUM_LINES-1:0] sense_q,
    input logic [NUM_LINES-1:0]   irq_level
);

    logic rd_stat, rd_ctrl, wr_stat, wr_ctrl;
    always_comb begin
        rd_stat = bus_valid && !bus_write && (bus_addr == ADDR_W'(REG_STAT_OFS));
        rd_ctrl = bus_valid && !bus_write && (bus_addr == ADDR_W'(REG_CTRL_OFS));
        wr_stat = bus_valid &&  bus_write && (bus_addr == ADDR_W'(REG_STAT_OFS));
        wr_ctrl = bus_valid &&  bus_write && (bus_addr == ADDR_W'(REG_CTRL_OFS));
    end

    always @(negedge clk) begin
        if (!rst_n) begin
            assert_reset_clear_R1: assert (irq_req == '0 && !nmi_req);
        end
    end

    assert_status_mirror_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat |-> (rdata_lo == irq_req));

    assert_nmi_mirror_R12: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |-> (rdata_lo[CTRL_FLAG_BIT] == nmi_req));

    assert_nmi_holds_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !(wr_ctrl && !wdata_lo[CTRL_FLAG_BIT])) |=> nmi_req);

    for (genvar i = 0; i < NUM_LINES; i++) begin : g_chk
        assert_flag_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
            ((sense_q[2*i +: 2] != 2'd0) && irq_req[i] && !(wr_stat && !wdata_lo[i]))
            |=> irq_req[i]);

        assert_level_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (sense_q[2*i +: 2] == 2'd0) |=> (irq_req[i] == !$past(irq_level[i])));
    end

endmodule

bind extirq_sense_ctrl extirq_sense_ctrl_chk #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_addr (bus_addr),
    .wdata_lo (bus_wdata[NUM_LINES-1:0]),
    .rdata_lo (bus_rdata[NUM_LINES-1:0]),
    .irq_req  (irq_req),
    .nmi_req  (nmi_req),
    .sense_q  (sense_q),
    .irq_level(irq_level)
);

// File: tb/sim_extirq_sense_ctrl.sv
module sim_extirq_sense_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  irq_pin = 8'hFF;
    logic        nmi_pin = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [2:0]  bus_addr = 3'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic [7:0]  irq_req;
    logic        nmi_req;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    extirq_sense_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_req(irq_req), .nmi_req(nmi_req)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [2:0] addr, output logic [15:0] data);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = addr;
        #1;
        data = bus_rdata;
        bus_valid = 1'b0;
    endtask

    task automatic wr(input logic [2:0] addr, input logic [15:0] data);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = addr; bus_wdata = data;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [15:0] v;
        logic [15:0] bitn;
        logic [15:0] exp;
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R1 reset state
        rd(3'd0, v); chk("R1 ctrl", v, 16'h8000);
        rd(3'd2, v); chk("R1 sense", v, 16'h0000);
        rd(3'd4, v); chk("R1 status", v, 16'h0000);
        chk("R1 outputs", {7'd0, nmi_req, irq_req}, 16'h0000);

        // R2 undecoded offsets
        wr(3'd6, 16'hFFFF);
        rd(3'd6, v); chk("R2 read 6", v, 16'h0000);
        rd(3'd3, v); chk("R2 read 3", v, 16'h0000);
        rd(3'd2, v); chk("R2 sense untouched", v, 16'h0000);
        rd(3'd0, v); chk("R2 ctrl untouched", v, 16'h8000);

        // R3 field placement and readback
        wr(3'd2, 16'hA5C3);
        rd(3'd2, v); chk("R3 readback", v, 16'hA5C3);
        for (int n = 0; n < 8; n++) begin
            exp = 16'((n % 4) << (2 * n));
            wr(3'd2, exp);
            rd(3'd2, v); chk("R3 field", v, exp);
        end

        // R4 R5 R6 R12 sweep: every line in every sense code
        for (int n = 0; n < 8; n++) begin
            for (int m = 0; m < 4; m++) begin
                bitn = 16'(1) << n;
                wr(3'd2, 16'(m << (2 * n)));
                wr(3'd4, 16'h0000);
                irq_pin[n] = 1'b0;
                tick(2);
                rd(3'd4, v); chk("R6 not yet after two edges", v, 16'h0000);
                tick(1);
                exp = (m != 2) ? bitn : 16'h0;
                rd(3'd4, v); chk("R5 falling pin", v, exp);
                chk("R12 irq_req", {8'd0, irq_req}, exp);
                wr(3'd4, ~bitn);
                exp = (m == 0) ? bitn : 16'h0;
                rd(3'd4, v); chk("R4 R7 clear while low", v, exp);
                irq_pin[n] = 1'b1;
                tick(3);
                exp = (m >= 2) ? bitn : 16'h0;
                rd(3'd4, v); chk("R4 R5 rising pin", v, exp);
                wr(3'd4, 16'h0000);
            end
        end

        // R7 selective clear
        wr(3'd2, 16'h5555);
        wr(3'd4, 16'h0000);
        irq_pin[0] = 1'b0; irq_pin[3] = 1'b0;
        tick(3);
        rd(3'd4, v); chk("R7 two flags", v, 16'h0009);
        wr(3'd4, 16'hFFFF);
        rd(3'd4, v); chk("R7 ones keep", v, 16'h0009);
        wr(3'd4, 16'hFFF7);
        rd(3'd4, v); chk("R7 clear line 3", v, 16'h0001);
        irq_pin = 8'hFF;
        tick(3);
        wr(3'd4, 16'h0000);
        rd(3'd4, v); chk("R7 all cleared", v, 16'h0000);

        // R8 event and clear in the same cycle
        irq_pin[2] = 1'b0;
        tick(2);
        wr(3'd4, 16'hFFFB);
        rd(3'd4, v); chk("R8 event wins", v, 16'h0004);
        irq_pin[2] = 1'b1;
        tick(3);
        wr(3'd4, 16'h0000);

        // R9 R10 R11 NMI
        nmi_pin = 1'b0;
        tick(1);
        rd(3'd0, v); chk("R9 level lag", v, 16'h8000);
        tick(1);
        rd(3'd0, v); chk("R9 level low", v, 16'h0000);
        tick(1);
        rd(3'd0, v); chk("R11 falling flag", v, 16'h0002);
        chk("R12 nmi_req", {15'd0, nmi_req}, 16'h0001);
        wr(3'd0, 16'h8002);
        rd(3'd0, v); chk("R9 R11 ro level, one keeps", v, 16'h0002);
        wr(3'd0, 16'h0000);
        rd(3'd0, v); chk("R11 clear", v, 16'h0000);
        wr(3'd0, 16'h0100);
        rd(3'd0, v); chk("R10 select rising", v, 16'h0100);
        nmi_pin = 1'b1;
        tick(3);
        rd(3'd0, v); chk("R10 R11 rising flag", v, 16'h8102);
        wr(3'd0, 16'h0100);
        nmi_pin = 1'b0;
        tick(3);
        rd(3'd0, v); chk("R10 falling ignored", v, 16'h0100);
        chk("R12 nmi_req low", {15'd0, nmi_req}, 16'h0000);

        finish_run();
    end

endmodule